// File: doc/BRIEF.md
# Key-Locked System Control Register File

This block is a bank of 32-bit control and status words behind a synchronous, word-addressed read/write bus covering 4 KiB (1024 words). It comes out of reset locked. While it is locked, only a one-bit scratch word and the two key ports accept writes. Software unlocks the bank by writing a 16-bit magic value to the unlock port and locks it again with a different magic value on the lock port. Every word offset belongs to one access class: read-write, read-only, write-only or unmapped. An access that its class forbids, or a write to a guarded word while the bank is locked, is discarded and produces a one-cycle error pulse.

The bank holds these words:
- a one-bit scratch word at word 0;
- a write-only lock port at word 1;
- a write-only unlock port at word 2;
- a read-only lock status at word 3;
- a group of configuration words starting at word 0x40, each with its own non-zero reset value;
- a reset-control word at word 0x80 (byte 0x200);
- a read-only identification word at word 0x14C.

An unlocked write to the reset-control word with bit 0 set stores the value and then raises a one-cycle soft-reset request.

Top module: `sysctl_keylock_regs`

## Requirements
- R1: After synchronous reset the bank is locked and `access_err`, `soft_rst_req` and `rd_data` are 0. The scratch word reads 0, the reset-control word reads 0, and configuration word i (i = 0..7 at word 0x40+i) reads {8'h18, i, i, 8'h01}.
- R2: A write to word 1 whose bits [15:0] equal 16'h767B sets the lock. Bits [31:16] are ignored. Any other value at word 1 leaves the lock unchanged and is not an error.
- R3: A write to word 2 whose bits [15:0] equal 16'hDF0D clears the lock. Bits [31:16] are ignored. Any other value at word 2 leaves the lock unchanged and is not an error.
- R4: While the bank is locked, a write to a configuration word or to the reset-control word is discarded and raises `access_err`.
- R5: Word 0 accepts writes whether or not the bank is locked. It stores only bit 0 of the written data and reads it back in bit 0, with bits [31:1] reading 0.
- R6: A write to a read-only word (word 3 or the identification word 0x14C) or to an unmapped word is discarded and raises `access_err`, even while the bank is unlocked.
- R7: A read of a write-only word (1 or 2) or of an unmapped word raises `access_err` and returns 0. Reads of mapped words return the stored value. Read data appears on `rd_data` after the clock edge that samples `rd_en`.
- R8: An unlocked write to word 0x80 with bit 0 set stores the full value and raises `soft_rst_req` for exactly one cycle after that edge. A write with bit 0 clear stores the value and raises no request.
- R9: `access_err` is registered: it is high for the one cycle that follows the edge sampling the offending access. Permitted accesses leave it low.
- R10: A read of word 3 returns the lock state in bit 0 (1 = locked), with the other bits 0. A read of word 0x14C returns the parameter `ID_WORD`.
- R11: While the bank is unlocked, configuration words store all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (10) | Word address (byte address / 4) |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| access_err | output | 1 | One-cycle pulse on a forbidden or locked access |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
The bench targets the key corners. It writes near-miss keys, which a design comparing the wrong bit range would accept. It writes keys with junk in the upper half, which a design comparing all 32 bits would reject.

It writes guarded words while the bank is locked and reads them back. A design that checks the lock after storing would show the new value. It writes read-only and unmapped words while the bank is unlocked. A design that applies the lock check first would miss the error. It reads the key ports, where a wrong class table would stay silent.

It also writes the reset-control word with bit 0 clear, with bit 0 set, and while locked. A design that pulses on any write, or that ignores the lock, would raise a request where none belongs.

// File: rtl/skr_pkg.sv
package skr_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RW   = 2'd1,
    ACC_RO   = 2'd2,
    ACC_WO   = 2'd3
  } acc_t;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned KEY_W      = 16;
  localparam logic [KEY_W-1:0] LOCK_KEY   = 16'h767B;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D;

  // Word indices whose position matters to software.
  localparam int unsigned SCRATCH_IDX = 0;
  localparam int unsigned LOCK_IDX    = 1;
  localparam int unsigned UNLOCK_IDX  = 2;
  localparam int unsigned STATUS_IDX  = 3;
  localparam int unsigned CFG_BASE    = 64;
  localparam int unsigned NUM_CFG     = 8;
  localparam int unsigned RSTCTL_IDX  = 128;
  localparam int unsigned ID_IDX      = 332;

  // Access class of a word index.
  function automatic acc_t classify(input logic [31:0] idx, input int unsigned ncfg);
    acc_t c;
    c = ACC_NONE;
    if (idx == 32'(SCRATCH_IDX) || idx == 32'(RSTCTL_IDX))
      c = ACC_RW;
    else if (idx == 32'(LOCK_IDX) || idx == 32'(UNLOCK_IDX))
      c = ACC_WO;
    else if (idx == 32'(STATUS_IDX) || idx == 32'(ID_IDX))
      c = ACC_RO;
    else if (idx >= 32'(CFG_BASE) && idx < 32'(CFG_BASE + ncfg))
      c = ACC_RW;
    return c;
  endfunction

  // Reset value of configuration word i.
  function automatic logic [WORD_W-1:0] cfg_reset(input int unsigned i);
    logic [WORD_W-1:0] v;
    v = 32'h1800_0001;
    v = v | (32'(i & 8'hFF) << 16) | (32'(i & 8'hFF) << 8);
    return v;
  endfunction

  function automatic logic key_match(input logic [KEY_W-1:0] d, input logic [KEY_W-1:0] key);
    return d == key;
  endfunction

endpackage

// File: rtl/skr_access_decode.sv
module skr_access_decode
  import skr_pkg::*;
#(
  parameter int unsigned NUM_CFG_P = NUM_CFG
) (
  input  logic [31:0] idx,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic        locked,
  output acc_t        cls,
  output logic        wr_bad,
  output logic        rd_bad,
  output logic        wr_commit,
  output logic        key_wr
);

  logic lock_exempt;

  always_comb begin
    cls         = classify(idx, NUM_CFG_P);
    lock_exempt = (idx == 32'(SCRATCH_IDX));
    // Class check first, lock check only for otherwise permitted words.
    wr_bad      = wr_en && ((cls == ACC_NONE) || (cls == ACC_RO) ||
                            ((cls == ACC_RW) && locked && !lock_exempt));
    rd_bad      = rd_en && ((cls == ACC_NONE) || (cls == ACC_WO));
    wr_commit   = wr_en && (cls == ACC_RW) && !wr_bad;
    key_wr      = wr_en && (cls == ACC_WO);
  end

endmodule

// File: rtl/skr_lock_ctrl.sv
module skr_lock_ctrl
  import skr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [31:0]      idx,
  input  logic [KEY_W-1:0] key_data,
  output logic             locked
);

  logic set_hit, clr_hit;

  always_comb begin
    set_hit = key_wr && (idx == 32'(LOCK_IDX))   && key_match(key_data, LOCK_KEY);
    clr_hit = key_wr && (idx == 32'(UNLOCK_IDX)) && key_match(key_data, UNLOCK_KEY);
  end

  always_ff @(posedge clk) begin
    if (rst)          locked <= 1'b1;
    else if (set_hit) locked <= 1'b1;
    else if (clr_hit) locked <= 1'b0;
  end

endmodule

// File: rtl/skr_reg_bank.sv
module skr_reg_bank
  import skr_pkg::*;
#(
  parameter int unsigned     NUM_CFG_P = NUM_CFG,
  parameter logic [31:0]     ID_WORD   = 32'h5C0A_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_commit,
  input  logic [31:0]       idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              locked,
  output logic [WORD_W-1:0] rd_word,
  output logic              srst_hit
);

  logic                               scratch_q;
  logic [WORD_W-1:0]                  rstctl_q;
  logic [NUM_CFG_P-1:0][WORD_W-1:0]   cfg_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch_q <= 1'b0;
      rstctl_q  <= '0;
    end else if (wr_commit) begin
      if (idx == 32'(SCRATCH_IDX)) scratch_q <= wdata[0];
      if (idx == 32'(RSTCTL_IDX))  rstctl_q  <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_CFG_P; g++) begin : g_cfg
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= cfg_reset(g);
      else if (wr_commit && idx == 32'(CFG_BASE + g))
        q <= wdata;
    end
    assign cfg_flat[g] = q;
  end

  always_comb begin
    rd_word = '0;
    if (idx == 32'(SCRATCH_IDX)) rd_word = {{(WORD_W-1){1'b0}}, scratch_q};
    if (idx == 32'(STATUS_IDX))  rd_word = {{(WORD_W-1){1'b0}}, locked};
    if (idx == 32'(RSTCTL_IDX))  rd_word = rstctl_q;
    if (idx == 32'(ID_IDX))      rd_word = ID_WORD;
    for (int i = 0; i < int'(NUM_CFG_P); i++)
      if (idx == 32'(CFG_BASE + i)) rd_word = cfg_flat[i];
  end

  assign srst_hit = wr_commit && (idx == 32'(RSTCTL_IDX)) && wdata[0];

endmodule

// File: rtl/sysctl_keylock_regs.sv
module sysctl_keylock_regs
  import skr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NCFG    = NUM_CFG,
  parameter logic [31:0] ID_WORD = 32'h5C0A_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              access_err,
  output logic              soft_rst_req
);

  logic [31:0] idx;
  acc_t        cls;
  logic        wr_bad, rd_bad, wr_commit, key_wr, locked, srst_hit;
  logic [31:0] rd_word;

  assign idx = 32'(addr);

  skr_access_decode #(.NUM_CFG_P(NCFG)) u_dec (
    .idx(idx), .wr_en(wr_en), .rd_en(rd_en), .locked(locked), .cls(cls),
    .wr_bad(wr_bad), .rd_bad(rd_bad), .wr_commit(wr_commit), .key_wr(key_wr)
  );

  skr_lock_ctrl u_lock (
    .clk(clk), .rst(rst), .key_wr(key_wr), .idx(idx),
    .key_data(wr_data[KEY_W-1:0]), .locked(locked)
  );

  skr_reg_bank #(.NUM_CFG_P(NCFG), .ID_WORD(ID_WORD)) u_bank (
    .clk(clk), .rst(rst), .wr_commit(wr_commit), .idx(idx), .wdata(wr_data),
    .locked(locked), .rd_word(rd_word), .srst_hit(srst_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data      <= '0;
      access_err   <= 1'b0;
      soft_rst_req <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_word;
      access_err   <= wr_bad || rd_bad;
      soft_rst_req <= srst_hit;
    end
  end

endmodule

// File: rtl/skr_checker.sv
module skr_checker
  import skr_pkg::*;
#(
  parameter int unsigned NCFG = NUM_CFG
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        rd_en,
  input logic [31:0] addr_idx,
  input logic [31:0] wdata,
  input logic        locked,
  input logic        wr_commit,
  input logic        access_err,
  input logic        soft_rst_req
);

  logic cfg_hit;
  assign cfg_hit = addr_idx >= 32'(CFG_BASE) && addr_idx < 32'(CFG_BASE + NCFG);

  a_r1_locked_after_reset: assert property (@(posedge clk) rst |=> locked);

  a_r2_lock_key: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_idx == 32'(LOCK_IDX) && wdata[15:0] == LOCK_KEY) |=> locked);

  a_r3_unlock_key: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_idx == 32'(UNLOCK_IDX) && wdata[15:0] == UNLOCK_KEY) |=> !locked);

  a_r2_lock_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (addr_idx == 32'(LOCK_IDX) || addr_idx == 32'(UNLOCK_IDX))) |=> $stable(locked));

  a_r4_locked_cfg_err: assert property (@(posedge clk) disable iff (rst)
    (wr_en && locked && cfg_hit) |=> access_err);

  a_r4_no_commit_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && locked) |-> addr_idx == 32'(SCRATCH_IDX));

  a_r8_srst_source: assert property (@(posedge clk) disable iff (rst)
    soft_rst_req |-> $past(wr_commit && addr_idx == 32'(RSTCTL_IDX) && wdata[0]));

  a_r9_commit_quiet: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && !rd_en) |=> !access_err);

endmodule

bind sysctl_keylock_regs skr_checker #(.NCFG(NCFG)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr_idx(idx),
  .wdata(wr_data), .locked(locked), .wr_commit(wr_commit),
  .access_err(access_err), .soft_rst_req(soft_rst_req)
);

// File: tb/sim_sysctl_keylock_regs.sv
module sim_sysctl_keylock_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        access_err, soft_rst_req;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    bit          chk_rd;
    logic [31:0] rd;
    bit          err;
    bit          srst;
    string       tag;
  } exp_t;
  exp_t q[$];

  localparam logic [31:0] ID = 32'h5C0A_0001;

  always #5 clk = ~clk;

  sysctl_keylock_regs u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .access_err(access_err),
    .soft_rst_req(soft_rst_req)
  );

  function automatic logic [31:0] cfg_rv(input int i);
    return {8'h18, 8'(i), 8'(i), 8'h01};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit we, input bit re, input logic [9:0] a, input logic [31:0] d,
                     input bit chk, input logic [31:0] rdv, input bit e, input bit s,
                     input string tag);
    exp_t it;
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0;
    it.chk_rd = chk; it.rd = rdv; it.err = e; it.srst = s; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input bit e, input bit s, input string tag);
    acc(1, 0, a, d, 0, '0, e, s, tag);
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] v, input bit e, input string tag);
    acc(0, 1, a, '0, 1, v, e, 0, tag);
  endtask

  // Monitor: compares outputs registered at the edge each item was pushed after.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        if (it.chk_rd) check({it.tag, " rd_data"}, rd_data, it.rd);
        check({it.tag, " access_err"}, 32'(access_err), 32'(it.err));
        check({it.tag, " soft_rst_req"}, 32'(soft_rst_req), 32'(it.srst));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R1 reset access_err", 32'(access_err), 0);
    check("R1 reset soft_rst_req", 32'(soft_rst_req), 0);
    check("R1 reset rd_data", rd_data, 0);

    rd(10'd3, 32'd1, 0, "R1 R10 locked status");
    rd(10'h40, cfg_rv(0), 0, "R1 cfg0 reset");
    rd(10'h47, cfg_rv(7), 0, "R1 cfg7 reset");
    rd(10'd0, 32'd0, 0, "R1 scratch reset");
    rd(10'h80, 32'd0, 0, "R1 rstctl reset");

    wr(10'h42, 32'hDEAD_BEEF, 1, 0, "R4 locked cfg write");
    rd(10'h42, cfg_rv(2), 0, "R4 cfg unchanged");
    wr(10'h80, 32'h1, 1, 0, "R4 R8 locked rstctl write");
    rd(10'h80, 32'd0, 0, "R4 rstctl unchanged");

    wr(10'd0, 32'hFFFF_FFFE, 0, 0, "R5 scratch write locked");
    rd(10'd0, 32'd0, 0, "R5 scratch bit0 only");
    wr(10'd0, 32'h0000_0003, 0, 0, "R5 scratch write 3");
    rd(10'd0, 32'd1, 0, "R5 scratch reads 1");

    wr(10'd2, 32'h0000_DF0C, 0, 0, "R3 wrong unlock key");
    rd(10'd3, 32'd1, 0, "R3 still locked");
    wr(10'd2, 32'h1234_DF0D, 0, 0, "R3 unlock key upper junk");
    rd(10'd3, 32'd0, 0, "R3 R10 unlocked status");

    wr(10'h42, 32'hDEAD_BEEF, 0, 0, "R11 cfg write unlocked");
    rd(10'h42, 32'hDEAD_BEEF, 0, "R11 cfg readback");

    wr(10'd3, 32'h1, 1, 0, "R6 write status ro");
    rd(10'd3, 32'd0, 0, "R6 status unchanged");
    wr(10'h14C, 32'h0, 1, 0, "R6 write id ro");
    rd(10'h14C, ID, 0, "R6 R10 id value");
    wr(10'h3FF, 32'h1234_5678, 1, 0, "R6 write unmapped");
    rd(10'h3FF, 32'd0, 1, "R7 read unmapped");
    rd(10'd1, 32'd0, 1, "R7 read lock port");
    rd(10'd2, 32'd0, 1, "R7 read unlock port");

    wr(10'h80, 32'h0000_0005, 0, 1, "R8 soft reset pulse");
    acc(0, 0, 10'd0, 32'd0, 0, '0, 0, 0, "R8 R9 pulse one cycle");
    rd(10'h80, 32'h5, 0, "R8 value stored");
    wr(10'h80, 32'h0000_0004, 0, 0, "R8 bit0 clear no pulse");

    wr(10'd1, 32'h0000_767A, 0, 0, "R2 wrong lock key");
    rd(10'd3, 32'd0, 0, "R2 still unlocked");
    wr(10'd1, 32'hFFFF_767B, 0, 0, "R2 lock key upper junk");
    rd(10'd3, 32'd1, 0, "R2 relocked");
    wr(10'h43, 32'h0, 1, 0, "R4 relocked cfg write");
    acc(0, 0, 10'd0, 32'd0, 0, '0, 0, 0, "R9 err one cycle");
    rd(10'h43, cfg_rv(3), 0, "R4 cfg3 unchanged");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule